// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block holds the floating-point status word of a processor's FPU and makes the exception decision at the end of every arithmetic operation. The arithmetic units report completion with a one-cycle valid pulse and a 5-bit vector of IEEE flags. The block stores these flags as the current exceptions and compares them with the trap-enable mask. It then does one of two things. If an enabled flag is present, it records the trap type "IEEE exception" and pulses a trap request. Otherwise it merges the flags into the sticky accrued field and clears the trap type.

The rounding-direction field is decoded into a one-hot select for the datapath. The whole word can be read at any time, and a constant version number appears in it. Software can write the word in three ways:
- a full write, which loads every writable field;
- a write that leaves the condition codes and queue flag untouched;
- a write that also keeps the current trap type.

Top module: `fpu_status_reg`

## Requirements
- R1: After reset every writable field is zero, so `rd_data_o` equals only the version constant, `trap_o` is low and rounding selects nearest-even.
- R2: An operation overwrites the current-exception field bits [4:0] with its flags, using the order invalid=bit4, overflow=bit3, underflow=bit2, divide-by-zero=bit1, inexact=bit0. The field becomes zero when no flag is raised.
- R3: When an operation's flags ANDed with the trap-enable field bits [27:23] are nonzero, `trap_o` is high for exactly one cycle, the cycle after the operation. The trap type field bits [16:14] becomes 3'b001.
- R4: When an operation does not trap, the accrued field bits [9:5] is ORed with its flags and the trap type becomes 3'b000. When it traps, the accrued field is left unchanged.
- R5: The rounding field bits [31:30] decodes one-hot on `rnd_mode_o`: 0 gives nearest-even on bit0, 1 gives toward zero on bit1, 2 gives toward +infinity on bit2, and 3 gives toward -infinity on bit3.
- R6: The version field bits [19:17] always reads as parameter `VERSION` and ignores writes. All unassigned bits (12, 20-22, 28-29) read zero.
- R7: A write with `wr_kind_i`=0 loads rounding, trap enables, trap type, queue flag bit 13, condition code bits [11:10], accrued and current exceptions from `wr_data_i`.
- R8: A write with `wr_kind_i`=1 loads the same fields except the condition codes and the queue flag, which keep their values.
- R9: A write with `wr_kind_i`=2 behaves like kind 1 and also keeps the trap type, while still loading the current exceptions.
- R10: A write with `wr_kind_i`=3 is ignored and leaves the register unchanged.
- R11: When a write (kind 0-2) and an operation occur in the same cycle, the write wins. The operation is dropped and raises no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | End-of-operation pulse |
| op_flags_i | input | 5 | IEEE flags of the finishing operation |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Write form: 0 full, 1 keep codes, 2 keep codes and trap type, 3 none |
| wr_data_i | input | 32 | Write value |
| rd_data_o | output | 32 | Current register value |
| rnd_mode_o | output | 4 | One-hot rounding direction |
| trap_o | output | 1 | Trap request strobe |

## Verification
The read value and the trap strobe come from registers. An operation or write presented before a rising edge therefore shows on `rd_data_o` and `trap_o` after that edge. `trap_o` falls again after the following edge. The bench drives inputs at the falling edge and samples one falling edge later, which is half a cycle after the updating edge. To show that the strobe is a single cycle wide, it samples once more a full cycle later. `rnd_mode_o` decodes the stored rounding field combinationally, so it is checked in the same sampling slot as the read-back of the write that changed it.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned FLAG_W   = 5;
  localparam int unsigned FTT_W    = 3;
  localparam int unsigned RD_W     = 2;
  localparam int unsigned FCC_W    = 2;
  localparam int unsigned VER_W    = 3;
  localparam int unsigned NRND     = 1 << RD_W;

  localparam int unsigned CEXC_LSB = 0;
  localparam int unsigned AEXC_LSB = 5;
  localparam int unsigned FCC_LSB  = 10;
  localparam int unsigned QNE_BIT  = 13;
  localparam int unsigned FTT_LSB  = 14;
  localparam int unsigned VER_LSB  = 17;
  localparam int unsigned TEM_LSB  = 23;
  localparam int unsigned RD_LSB   = 30;

  localparam logic [FTT_W-1:0] FTT_NONE = '0;
  localparam logic [FTT_W-1:0] FTT_IEEE = 3'b001;

  typedef enum logic [1:0] {
    WR_FULL    = 2'd0,
    WR_KEEP_CC = 2'd1,
    WR_KEEP_TT = 2'd2,
    WR_NONE    = 2'd3
  } wr_kind_e;

  typedef struct packed {
    logic [RD_W-1:0]   rd;
    logic [FLAG_W-1:0] tem;
    logic [FTT_W-1:0]  ftt;
    logic              qne;
    logic [FCC_W-1:0]  fcc;
    logic [FLAG_W-1:0] aexc;
    logic [FLAG_W-1:0] cexc;
  } fsr_t;
endpackage

// File: rtl/fsr_exc_eval.sv
module fsr_exc_eval
  import fsr_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] tem_i,
  input  logic [FLAG_W-1:0] aexc_i,
  output logic              trap_o,
  output logic [FLAG_W-1:0] aexc_o,
  output logic [FTT_W-1:0]  ftt_o
);
  always_comb begin
    trap_o = |(flags_i & tem_i);
    // accrual only when no trap is taken
    aexc_o = trap_o ? aexc_i : (aexc_i | flags_i);
    ftt_o  = trap_o ? FTT_IEEE : FTT_NONE;
  end
endmodule

// File: rtl/fsr_rnd_decode.sv
module fsr_rnd_decode
  import fsr_pkg::*;
(
  input  logic [RD_W-1:0] rd_i,
  output logic [NRND-1:0] sel_o
);
  for (genvar g = 0; g < NRND; g++) begin : g_sel
    assign sel_o[g] = (rd_i == RD_W'(g));
  end
endmodule

// File: rtl/fsr_pack.sv
module fsr_pack
  import fsr_pkg::*;
#(
  parameter logic [VER_W-1:0] VERSION = 3'd4
) (
  input  fsr_t            st_i,
  output logic [XLEN-1:0] word_o
);
  always_comb begin
    word_o = '0;
    word_o[RD_LSB  +: RD_W]   = st_i.rd;
    word_o[TEM_LSB +: FLAG_W] = st_i.tem;
    word_o[VER_LSB +: VER_W]  = VERSION;
    word_o[FTT_LSB +: FTT_W]  = st_i.ftt;
    word_o[QNE_BIT]           = st_i.qne;
    word_o[FCC_LSB +: FCC_W]  = st_i.fcc;
    word_o[AEXC_LSB +: FLAG_W] = st_i.aexc;
    word_o[CEXC_LSB +: FLAG_W] = st_i.cexc;
  end
endmodule

// File: rtl/fpu_status_reg.sv
module fpu_status_reg
  import fsr_pkg::*;
#(
  parameter logic [VER_W-1:0] VERSION = 3'd4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [FLAG_W-1:0] op_flags_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_kind_i,
  input  logic [XLEN-1:0]   wr_data_i,
  output logic [XLEN-1:0]   rd_data_o,
  output logic [NRND-1:0]   rnd_mode_o,
  output logic              trap_o
);
  fsr_t              st_q;
  logic              trap_q;
  logic              hit;
  logic [FLAG_W-1:0] aexc_nxt;
  logic [FTT_W-1:0]  ftt_nxt;
  logic              wr_act;
  wr_kind_e          kind;

  assign kind   = wr_kind_e'(wr_kind_i);
  assign wr_act = wr_en_i && (kind != WR_NONE);

  fsr_exc_eval i_eval (
    .flags_i (op_flags_i),
    .tem_i   (st_q.tem),
    .aexc_i  (st_q.aexc),
    .trap_o  (hit),
    .aexc_o  (aexc_nxt),
    .ftt_o   (ftt_nxt)
  );

  fsr_rnd_decode i_rnd (
    .rd_i  (st_q.rd),
    .sel_o (rnd_mode_o)
  );

  fsr_pack #(.VERSION(VERSION)) i_pack (
    .st_i   (st_q),
    .word_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      trap_q <= 1'b0;
    end else begin
      trap_q <= 1'b0;
      if (wr_act) begin
        st_q.rd   <= wr_data_i[RD_LSB +: RD_W];
        st_q.tem  <= wr_data_i[TEM_LSB +: FLAG_W];
        st_q.aexc <= wr_data_i[AEXC_LSB +: FLAG_W];
        st_q.cexc <= wr_data_i[CEXC_LSB +: FLAG_W];
        if (kind != WR_KEEP_TT) st_q.ftt <= wr_data_i[FTT_LSB +: FTT_W];
        if (kind == WR_FULL) begin
          st_q.fcc <= wr_data_i[FCC_LSB +: FCC_W];
          st_q.qne <= wr_data_i[QNE_BIT];
        end
      end else if (op_valid_i) begin
        st_q.cexc <= op_flags_i;
        st_q.aexc <= aexc_nxt;
        st_q.ftt  <= ftt_nxt;
        trap_q    <= hit;
      end
    end
  end

  assign trap_o = trap_q;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
  import fsr_pkg::*;
#(
  parameter logic [VER_W-1:0] VERSION = 3'd4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [FLAG_W-1:0] op_flags_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_kind_i,
  input logic [XLEN-1:0]   wr_data_i,
  input logic [XLEN-1:0]   rd_data_o,
  input logic [NRND-1:0]   rnd_mode_o,
  input logic              trap_o
);
  logic op_only;
  logic wr_real;
  assign wr_real = wr_en_i && (wr_kind_i != 2'd3);
  assign op_only = op_valid_i && !wr_real;

  a_r2_cexc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_only |=> rd_data_o[CEXC_LSB +: FLAG_W] == $past(op_flags_i));

  a_r3_trap_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_only && |(op_flags_i & rd_data_o[TEM_LSB +: FLAG_W]))
    |=> (trap_o && rd_data_o[FTT_LSB +: FTT_W] == FTT_IEEE));

  a_r3_trap_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(op_only));

  a_r4_accrue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_only && !(|(op_flags_i & rd_data_o[TEM_LSB +: FLAG_W])))
    |=> (!trap_o && rd_data_o[FTT_LSB +: FTT_W] == FTT_NONE &&
         rd_data_o[AEXC_LSB +: FLAG_W] ==
           ($past(rd_data_o[AEXC_LSB +: FLAG_W]) | $past(op_flags_i))));

  a_r4_hold_on_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $stable(rd_data_o[AEXC_LSB +: FLAG_W]));

  a_r5_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rnd_mode_o) == 1);

  a_r6_version: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[VER_LSB +: VER_W] == VERSION);

  a_r8_keep_cc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_kind_i == 2'd1 || wr_kind_i == 2'd2))
    |=> $stable(rd_data_o[QNE_BIT:FCC_LSB]));

  a_r9_keep_tt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == 2'd2) |=> $stable(rd_data_o[FTT_LSB +: FTT_W]));

  a_r10_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == 2'd3 && !op_valid_i) |=> $stable(rd_data_o));

  a_r11_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_real |=> (!trap_o && rd_data_o[CEXC_LSB +: FLAG_W] ==
                 $past(wr_data_i[CEXC_LSB +: FLAG_W])));
endmodule

bind fpu_status_reg fsr_checker #(.VERSION(VERSION)) i_fsr_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_flags_i (op_flags_i),
  .wr_en_i    (wr_en_i),
  .wr_kind_i  (wr_kind_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .rnd_mode_o (rnd_mode_o),
  .trap_o     (trap_o)
);

// File: tb/test_fpu_status_reg.sv
`timescale 1ns/1ps
module test_fpu_status_reg;
  localparam logic [31:0] VERW = 32'h0008_0000; // version 4 at [19:17]

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [4:0]  op_flags_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_kind_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [3:0]  rnd_mode_o;
  logic        trap_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  fpu_status_reg #(.VERSION(3'd4)) i_fpu_status_reg (.*);

  function automatic logic [31:0] mk(input logic [1:0] rd, input logic [4:0] tem,
      input logic [2:0] ftt, input logic qne, input logic [1:0] fcc,
      input logic [4:0] aexc, input logic [4:0] cexc);
    return {rd, 2'b00, tem, 3'b000, 3'b000, ftt, qne, 1'b0, fcc, aexc, cexc};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] kind, input logic [31:0] d);
    wr_en_i = 1'b1; wr_kind_i = kind; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic op(input logic [4:0] f);
    op_valid_i = 1'b1; op_flags_i = f;
    step();
    op_valid_i = 1'b0; op_flags_i = '0;
  endtask

  task automatic t_reset();
    chk("R1 read", rd_data_o, VERW);
    chk("R1 trap", {31'b0, trap_o}, 32'd0);
    chk("R1 rnd", {28'b0, rnd_mode_o}, 32'h1);
  endtask

  task automatic t_full_write();
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R7 all ones", rd_data_o, 32'hCF89_EFFF);
    wr(2'd0, 32'h0000_0000);
    chk("R6 version kept", rd_data_o, VERW);
    wr(2'd0, mk(2'd1, 5'h0A, 3'd5, 1'b1, 2'd2, 5'h11, 5'h06));
    chk("R7 fields", rd_data_o, mk(2'd1, 5'h0A, 3'd5, 1'b1, 2'd2, 5'h11, 5'h06) | VERW);
  endtask

  task automatic t_round();
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, mk(2'(i), 5'h0, 3'd0, 1'b0, 2'd0, 5'h0, 5'h0));
      chk("R5 decode", {28'b0, rnd_mode_o}, 32'(1 << i));
    end
  endtask

  task automatic t_accrue();
    wr(2'd0, 32'h0);
    op(5'b00001);
    chk("R2 cexc nx", rd_data_o, mk(2'd0, 5'h0, 3'd0, 1'b0, 2'd0, 5'h01, 5'h01) | VERW);
    chk("R4 no trap", {31'b0, trap_o}, 32'd0);
    op(5'b10000);
    chk("R4 accrue nv", rd_data_o, mk(2'd0, 5'h0, 3'd0, 1'b0, 2'd0, 5'h11, 5'h10) | VERW);
    op(5'b00000);
    chk("R2 cexc zero", rd_data_o, mk(2'd0, 5'h0, 3'd0, 1'b0, 2'd0, 5'h11, 5'h00) | VERW);
  endtask

  task automatic t_trap();
    wr(2'd0, mk(2'd0, 5'b01000, 3'd0, 1'b0, 2'd0, 5'h0, 5'h0));
    op(5'b01001);
    chk("R3 trap high", {31'b0, trap_o}, 32'd1);
    chk("R3 R4 trap state", rd_data_o, mk(2'd0, 5'b01000, 3'd1, 1'b0, 2'd0, 5'h0, 5'b01001) | VERW);
    step();
    chk("R3 trap one cycle", {31'b0, trap_o}, 32'd0);
    op(5'b00001);
    chk("R4 ftt cleared", rd_data_o, mk(2'd0, 5'b01000, 3'd0, 1'b0, 2'd0, 5'h01, 5'h01) | VERW);
    chk("R3 disabled no trap", {31'b0, trap_o}, 32'd0);
  endtask

  task automatic t_restricted();
    wr(2'd0, mk(2'd0, 5'h0, 3'd5, 1'b1, 2'd2, 5'h0, 5'h0));
    wr(2'd1, mk(2'd1, 5'h03, 3'd0, 1'b0, 2'd1, 5'h04, 5'h02));
    chk("R8 keep cc", rd_data_o, mk(2'd1, 5'h03, 3'd0, 1'b1, 2'd2, 5'h04, 5'h02) | VERW);
    wr(2'd0, mk(2'd0, 5'h0, 3'd6, 1'b0, 2'd3, 5'h0, 5'h0));
    wr(2'd2, mk(2'd2, 5'h10, 3'd7, 1'b1, 2'd0, 5'h08, 5'h1F));
    chk("R9 keep tt", rd_data_o, mk(2'd2, 5'h10, 3'd6, 1'b0, 2'd3, 5'h08, 5'h1F) | VERW);
    wr(2'd3, 32'hFFFF_FFFF);
    chk("R10 ignored", rd_data_o, mk(2'd2, 5'h10, 3'd6, 1'b0, 2'd3, 5'h08, 5'h1F) | VERW);
  endtask

  task automatic t_collide();
    wr(2'd0, mk(2'd0, 5'h1F, 3'd0, 1'b0, 2'd0, 5'h0, 5'h0));
    op_valid_i = 1'b1; op_flags_i = 5'h1F;
    wr_en_i = 1'b1; wr_kind_i = 2'd0;
    wr_data_i = mk(2'd0, 5'h1F, 3'd0, 1'b0, 2'd0, 5'h0, 5'h02);
    step();
    wr_en_i = 1'b0; op_valid_i = 1'b0; op_flags_i = '0;
    chk("R11 no trap", {31'b0, trap_o}, 32'd0);
    chk("R11 write wins", rd_data_o, mk(2'd0, 5'h1F, 3'd0, 1'b0, 2'd0, 5'h0, 5'h02) | VERW);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_full_write();
    t_round();
    t_accrue();
    t_trap();
    t_restricted();
    t_collide();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule